// File: doc/BRIEF.md
# Receive Clock Speed Guard

This block watches the receive clock that an Ethernet PHY returns for one port and decides, from its period alone, whether that clock runs at the fast rate (25 MHz, for 100 Mb/s operation) or the slow rate (10 MHz, for 10 Mb/s operation). It measures the period against its own 50 MHz reference clock. A clock that stops at either level counts as slow. Periods that fall between the two thresholds leave the previous decision untouched. A new decision only takes effect after it has been seen without a break for 620 ns.

The decided speed is compared with the configured speed select. A disagreement raises a mismatch flag. If automatic protection is enabled, the port is also isolated and a level interrupt is raised. The interrupt stays up until it is acknowledged. Isolation lifts by itself once the clock agrees with the configured speed again, and no software action is needed for that. A change of speed select that brings the two back into agreement clears the mismatch in the same cycle. On reset, the block takes its decided speed from speed select, so the clock is assumed correct at start.

Top module: `rxclk_speed_guard`

## Requirements
- R1: While reset is high, speedFast is loaded from spdSel. After reset, mismatch, isolate and irq are 0 and speedFast equals the spdSel value held during reset.
- R2: A receive clock whose rising edges are at most 3 reference cycles (60 ns) apart is classed as fast, so speedFast becomes 1.
- R3: A receive clock whose rising edges are at least 4 reference cycles (80 ns) apart is classed as slow, so speedFast becomes 0. A clock held at a constant level is also classed as slow.
- R4: A clock whose measured periods fall in the band between the two thresholds never changes speedFast, whichever speed it currently shows. At the 20 ns timebase this includes a 70 ns clock that is measured alternately as 3 and 4 cycles.
- R5: speedFast changes only after the opposite classification has been seen without a break for 31 reference cycles (620 ns). A disturbance shorter than that, such as the clock stopping for 12 cycles, leaves speedFast unchanged.
- R6: mismatch is 1 exactly when speedFast differs from spdSel (spdSel 1 = 100 Mb/s, 0 = 10 Mb/s). A change of spdSel updates mismatch in the same cycle, without any filter delay.
- R7: With autoProt 1, isolate rises one cycle after mismatch becomes 1. With autoProt 0, isolate stays 0 while mismatch still reports.
- R8: isolate falls one cycle after mismatch clears, whether the clock recovered or spdSel changed, with no acknowledge needed.
- R9: irq rises in the same cycle as isolate rises and stays 1 until irqAck is sampled high. A new isolation in the same cycle as an acknowledge wins, so irq stays 1.
- R10: irq is never raised while autoProt is 0, even when mismatch is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock, also the measurement timebase |
| rst | input | 1 | Synchronous active-high reset |
| rxClk | input | 1 | Raw receive clock from the PHY, asynchronous |
| spdSel | input | 1 | Configured speed: 1 = 100 Mb/s (25 MHz), 0 = 10 Mb/s (10 MHz) |
| autoProt | input | 1 | Enables isolation on mismatch |
| irqAck | input | 1 | Clears the interrupt when high at a clock edge |
| speedFast | output | 1 | Decided speed: 1 = fast clock, 0 = slow clock |
| mismatch | output | 1 | Decided speed disagrees with spdSel |
| isolate | output | 1 | Port isolated because of mismatch |
| irq | output | 1 | Level interrupt, set when isolation begins |

## Verification
The bench stops the receive clock and samples speedFast 20 cycles later and again 60 cycles later. This separates a correct 31-cycle filter from a filter that is too short, which would switch too early, or one that never fires, which would never switch. A 12-cycle stoppage and a 70 ns clock are used to confirm that short disturbances and the hold band change nothing. A design without the filter, or one whose thresholds are off by a cycle, would flip speedFast there. A speed-select change is checked one time step after it is driven, which catches a mismatch path that waits on a register or on the filter. The bench also checks an acknowledge that coincides with a fresh isolation, which catches an interrupt where the clear wins over the set.

// File: rtl/spdguard_pkg.sv
`timescale 1ns/1ps
package spdguard_pkg;

  // Classification of one measured receive-clock period
  typedef enum logic [1:0] {
    CLS_HOLD = 2'd0,
    CLS_FAST = 2'd1,
    CLS_SLOW = 2'd2
  } spd_class_e;

  // Result of the period measurement, valid for one reference cycle
  typedef struct packed {
    logic       valid;
    spd_class_e cls;
  } period_meas_t;

  // Strobes from control to the datapath filter counter
  typedef struct packed {
    logic filtStep;
    logic filtClear;
  } filt_ctrl_t;

endpackage

// File: rtl/spdguard_datapath.sv
`timescale 1ns/1ps
module spdguard_datapath
  import spdguard_pkg::*;
#(
  parameter int FAST_MAX_CYC = 3,
  parameter int SLOW_MIN_CYC = 4,
  parameter int FILTER_CYC   = 31,
  parameter int SYNC_STAGES  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rxClkRaw,
  input  filt_ctrl_t   filtCtrl,
  output period_meas_t meas,
  output logic         filtDone
);

  localparam int CNT_W  = $clog2(SLOW_MIN_CYC + 1);
  localparam int FILT_W = $clog2(FILTER_CYC + 1);
  localparam logic [CNT_W-1:0]  FAST_LIM  = CNT_W'(FAST_MAX_CYC);
  localparam logic [CNT_W-1:0]  SLOW_LIM  = CNT_W'(SLOW_MIN_CYC);
  localparam logic [FILT_W-1:0] FILT_LAST = FILT_W'(FILTER_CYC - 1);

  // Synchronizer chain bringing the receive clock into the reference domain
  logic [SYNC_STAGES-1:0] syncQ;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    logic stageIn;
    if (s == 0) begin : g_first
      assign stageIn = rxClkRaw;
    end else begin : g_next
      assign stageIn = syncQ[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst) syncQ[s] <= 1'b0;
      else     syncQ[s] <= stageIn;
    end
  end

  logic rxLevel;
  logic rxPrev;
  logic rxRise;
  logic primed;
  logic [CNT_W-1:0] periodCnt;
  logic [FILT_W-1:0] filtCnt;

  assign rxLevel = syncQ[SYNC_STAGES-1];
  assign rxRise  = rxLevel & ~rxPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxPrev <= 1'b0;
      primed <= 1'b0;
    end else begin
      rxPrev <= rxLevel;
      if (rxRise) primed <= 1'b1;
    end
  end

  // Reference cycles since the last rising edge, saturating at the slow limit
  always_ff @(posedge clk) begin
    if (rst)                    periodCnt <= '0;
    else if (rxRise)            periodCnt <= CNT_W'(1);
    else if (periodCnt < SLOW_LIM) periodCnt <= periodCnt + CNT_W'(1);
  end

  // Classify a completed period, or a period already too long to be fast
  always_comb begin
    meas.valid = 1'b0;
    meas.cls   = CLS_HOLD;
    if (rxRise && primed) begin
      meas.valid = 1'b1;
      if (periodCnt <= FAST_LIM)      meas.cls = CLS_FAST;
      else if (periodCnt >= SLOW_LIM) meas.cls = CLS_SLOW;
      else                            meas.cls = CLS_HOLD;
    end else if (periodCnt >= SLOW_LIM) begin
      meas.valid = 1'b1;
      meas.cls   = CLS_SLOW;
    end
  end

  // Sustained-change filter counter
  assign filtDone = filtCtrl.filtStep && (filtCnt == FILT_LAST);

  always_ff @(posedge clk) begin
    if (rst || filtCtrl.filtClear || filtDone) filtCnt <= '0;
    else if (filtCtrl.filtStep)                filtCnt <= filtCnt + FILT_W'(1);
  end

endmodule

// File: rtl/spdguard_control.sv
`timescale 1ns/1ps
module spdguard_control
  import spdguard_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         spdSel,
  input  logic         autoProt,
  input  logic         irqAck,
  input  period_meas_t meas,
  input  logic         filtDone,
  output filt_ctrl_t   filtCtrl,
  output logic         speedFast,
  output logic         mismatch,
  output logic         isolate,
  output logic         irq
);

  spd_class_e candQ;
  logic detFastQ;
  logic isoQ;
  logic irqQ;
  logic candFast;
  logic differs;
  logic isoStart;

  // Most recent classification seen by the datapath
  always_ff @(posedge clk) begin
    if (rst)             candQ <= CLS_HOLD;
    else if (meas.valid) candQ <= meas.cls;
  end

  assign candFast = (candQ == CLS_FAST);
  assign differs  = (candQ != CLS_HOLD) && (candFast != detFastQ);

  always_comb begin
    filtCtrl.filtStep  = differs;
    filtCtrl.filtClear = !differs;
  end

  // Decided speed: seeded from the speed select, switched only by the filter
  always_ff @(posedge clk) begin
    if (rst)           detFastQ <= spdSel;
    else if (filtDone) detFastQ <= candFast;
  end

  assign mismatch = detFastQ ^ spdSel;
  assign isoStart = autoProt && mismatch && !isoQ;

  always_ff @(posedge clk) begin
    if (rst) isoQ <= 1'b0;
    else     isoQ <= autoProt && mismatch;
  end

  always_ff @(posedge clk) begin
    if (rst)           irqQ <= 1'b0;
    else if (isoStart) irqQ <= 1'b1;
    else if (irqAck)   irqQ <= 1'b0;
  end

  assign speedFast = detFastQ;
  assign isolate   = isoQ;
  assign irq       = irqQ;

endmodule

// File: rtl/rxclk_speed_guard.sv
`timescale 1ns/1ps
module rxclk_speed_guard
  import spdguard_pkg::*;
#(
  parameter int REF_PERIOD_NS = 20,
  parameter int FAST_MAX_NS   = 60,
  parameter int SLOW_MIN_NS   = 80,
  parameter int FILTER_NS     = 620,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxClk,
  input  logic spdSel,
  input  logic autoProt,
  input  logic irqAck,
  output logic speedFast,
  output logic mismatch,
  output logic isolate,
  output logic irq
);

  localparam int FAST_MAX_CYC = FAST_MAX_NS / REF_PERIOD_NS;
  localparam int SLOW_MIN_CYC = (SLOW_MIN_NS + REF_PERIOD_NS - 1) / REF_PERIOD_NS;
  localparam int FILTER_CYC   = (FILTER_NS + REF_PERIOD_NS - 1) / REF_PERIOD_NS;

  period_meas_t meas;
  filt_ctrl_t   filtCtrl;
  logic         filtDone;

  spdguard_datapath #(
    .FAST_MAX_CYC (FAST_MAX_CYC),
    .SLOW_MIN_CYC (SLOW_MIN_CYC),
    .FILTER_CYC   (FILTER_CYC),
    .SYNC_STAGES  (SYNC_STAGES)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .rxClkRaw (rxClk),
    .filtCtrl (filtCtrl),
    .meas     (meas),
    .filtDone (filtDone)
  );

  spdguard_control i_ctl (
    .clk       (clk),
    .rst       (rst),
    .spdSel    (spdSel),
    .autoProt  (autoProt),
    .irqAck    (irqAck),
    .meas      (meas),
    .filtDone  (filtDone),
    .filtCtrl  (filtCtrl),
    .speedFast (speedFast),
    .mismatch  (mismatch),
    .isolate   (isolate),
    .irq       (irq)
  );

endmodule

// File: rtl/spdguard_checker.sv
`timescale 1ns/1ps
module spdguard_checker (
  input logic clk,
  input logic rst,
  input logic autoProt,
  input logic irqAck,
  input logic speedFast,
  input logic mismatch,
  input logic isolate,
  input logic irq,
  input logic filtDone
);

  a_r5_switch_needs_filter: assert property (@(posedge clk) disable iff (rst)
    (!$stable(speedFast) && !$past(rst)) |-> $past(filtDone));

  a_r7_no_iso_without_prot: assert property (@(posedge clk) disable iff (rst)
    !autoProt |=> !isolate);

  a_r8_auto_release: assert property (@(posedge clk) disable iff (rst)
    !mismatch |=> !isolate);

  a_r9_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq && !irqAck) |=> irq);

  a_r9_irq_with_iso: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $rose(isolate));

endmodule

bind rxclk_speed_guard spdguard_checker i_chk (
  .clk       (clk),
  .rst       (rst),
  .autoProt  (autoProt),
  .irqAck    (irqAck),
  .speedFast (speedFast),
  .mismatch  (mismatch),
  .isolate   (isolate),
  .irq       (irq),
  .filtDone  (filtDone)
);

// File: tb/test_rxclk_speed_guard.sv
`timescale 1ns/1ps
module test_rxclk_speed_guard;

  localparam int CLK_PERIOD = 20;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxClk = 1'b0;
  logic spdSel = 1'b1;
  logic autoProt = 1'b0;
  logic irqAck = 1'b0;
  logic speedFast, mismatch, isolate, irq;

  int rxHalf = 20;
  bit rxRun = 1'b1;
  int nChecks = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always begin
    if (rxRun) begin
      #(rxHalf);
      rxClk = ~rxClk;
    end else begin
      #5;
    end
  end

  rxclk_speed_guard i_rxclk_speed_guard (
    .clk(clk), .rst(rst), .rxClk(rxClk), .spdSel(spdSel),
    .autoProt(autoProt), .irqAck(irqAck), .speedFast(speedFast),
    .mismatch(mismatch), .isolate(isolate), .irq(irq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(logic sel);
    @(negedge clk);
    rst = 1'b1;
    spdSel = sel;
    waitCycles(4);
    rst = 1'b0;
    waitCycles(1);
  endtask

  task automatic ackIrq();
    irqAck = 1'b1;
    waitCycles(1);
    irqAck = 1'b0;
  endtask

  // Watch n cycles; count cycles where speedFast leaves expSpeed or isolate is high
  task automatic watchSteady(string req, int n, logic expSpeed);
    int bad = 0;
    int isoSeen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (speedFast !== expSpeed) bad++;
      if (isolate === 1'b1) isoSeen++;
    end
    check(req, "cycles with speed changed", bad, 0);
    if (mismatch === 1'b0) check(req, "cycles isolated", isoSeen, 0);
  endtask

  task automatic testResetFast();
    rxHalf = 20; rxRun = 1'b1; autoProt = 1'b0;
    doReset(1'b1);
    check("R1", "speedFast after reset", speedFast, 1);
    check("R1", "mismatch after reset", mismatch, 0);
    check("R1", "isolate after reset", isolate, 0);
    check("R1", "irq after reset", irq, 0);
    waitCycles(100);
    check("R2", "fast clock kept fast", speedFast, 1);
  endtask

  task automatic testFilterDelay();
    doReset(1'b0);
    check("R1", "speedFast seeded slow", speedFast, 0);
    check("R1", "mismatch after reset", mismatch, 0);
    waitCycles(20);
    check("R5", "no switch before 620 ns", speedFast, 0);
    waitCycles(40);
    check("R2", "40 ns clock detected fast", speedFast, 1);
    check("R6", "mismatch vs slow select", mismatch, 1);
    check("R7", "no isolate without protection", isolate, 0);
    check("R10", "no irq without protection", irq, 0);
  endtask

  task automatic testIsolate();
    autoProt = 1'b1;
    waitCycles(1);
    check("R7", "isolate one cycle later", isolate, 1);
    check("R9", "irq with isolation", irq, 1);
    waitCycles(5);
    check("R9", "irq held until ack", irq, 1);
    ackIrq();
    check("R9", "irq cleared by ack", irq, 0);
    check("R7", "isolate kept after ack", isolate, 1);
  endtask

  task automatic testInstantClear();
    spdSel = 1'b1;
    #1;
    check("R6", "mismatch clears at once", mismatch, 0);
    waitCycles(1);
    check("R8", "isolate released", isolate, 0);
    check("R6", "speedFast untouched", speedFast, 1);
  endtask

  task automatic testStopClock();
    rxRun = 1'b0;
    waitCycles(20);
    check("R5", "stopped clock not yet slow", speedFast, 1);
    waitCycles(40);
    check("R3", "stopped clock reads slow", speedFast, 0);
    check("R6", "mismatch vs fast select", mismatch, 1);
    check("R7", "isolated on mismatch", isolate, 1);
    check("R9", "irq on new isolation", irq, 1);
    ackIrq();
  endtask

  task automatic testRecovery();
    rxHalf = 20; rxRun = 1'b1;
    waitCycles(60);
    check("R8", "speed back to fast", speedFast, 1);
    check("R8", "mismatch gone", mismatch, 0);
    check("R8", "isolation lifted", isolate, 0);
    check("R9", "no irq on release", irq, 0);
  endtask

  task automatic testGlitch();
    int slowSeen = 0;
    rxRun = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (speedFast !== 1'b1) slowSeen++;
    end
    rxRun = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (speedFast !== 1'b1) slowSeen++;
    end
    check("R5", "short stop causes no switch", slowSeen, 0);
    check("R5", "still not isolated", isolate, 0);
  endtask

  task automatic testHoldBand();
    rxHalf = 35;
    watchSteady("R4", 200, 1'b1);
    rxHalf = 50;
    waitCycles(80);
    check("R3", "100 ns clock reads slow", speedFast, 0);
    check("R7", "isolated on slow clock", isolate, 1);
    ackIrq();
    rxHalf = 35;
    watchSteady("R4", 200, 1'b0);
  endtask

  task automatic testNoProt();
    autoProt = 1'b0;
    waitCycles(1);
    check("R7", "mismatch still reported", mismatch, 1);
    check("R7", "isolate low without protection", isolate, 0);
    spdSel = 1'b0;
    #1;
    check("R6", "agreeing select clears at once", mismatch, 0);
    waitCycles(1);
    spdSel = 1'b1;
    #1;
    check("R6", "disagreeing select sets at once", mismatch, 1);
    begin
      int hits = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (irq !== 1'b0 || isolate !== 1'b0) hits++;
      end
      check("R10", "no irq or isolate while unprotected", hits, 0);
    end
    autoProt = 1'b1;
    irqAck = 1'b1;
    waitCycles(1);
    check("R9", "new isolation beats ack", irq, 1);
    check("R7", "isolate after enabling protection", isolate, 1);
    waitCycles(1);
    irqAck = 1'b0;
    check("R9", "ack then clears irq", irq, 0);
  endtask

  initial begin
    testResetFast();
    testFilterDelay();
    testIsolate();
    testInstantClear();
    testStopClock();
    testRecovery();
    testGlitch();
    testHoldBand();
    testNoProt();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule